// File: doc/BRIEF.md
# Coincident-Selection RAM Array

A small static RAM whose storage is a square grid of single-bit cells. The word address is split in two: the upper bits feed a row decoder and the lower bits feed a column decoder. A cell takes part in an access only where its active row line crosses its active column line. Chip-select enables the column decoder and nothing else. With chip-select low, no column line is active, so no cell can be read or written.

The data width is a parameter. With one bit per word the 4x4 grid holds sixteen one-bit words. With two bits per word, each column-decoder line selects a pair of adjacent physical columns, and the grid holds eight two-bit words. Writes are stored on the rising clock edge. Reads are combinational from the selected cells, are merged through an OR of the cell outputs, and reach a tri-state output buffer that is enabled only for a selected read. A drive-enable output shows the state of that buffer.

Top module: `coinc_ram`

## Requirements
- R1: In the one-bit organisation, addr_i[3:2] selects the row r and addr_i[1:0] selects the column c. Cells are numbered row-major (cell 4r+c), so address value n maps to cell n. A write changes only the addressed cell.
- R2: Address 4'b1001 selects row 2 and column 1, which is cell 9 alone. Its row neighbour (cell 10), its column neighbour (cell 13) and cell 8 keep their values.
- R3: While cs_i=0, the column decoder outputs are all 0. A write request stores nothing, drive_o=0 and data_o is high-impedance.
- R4: A write (cs_i=1, we_i=1) takes effect at the rising edge of clk_i. Throughout the write, drive_o=0.
- R5: A read (cs_i=1, we_i=0) gives drive_o=1, and data_o equals the selected cell(s) in the same cycle, with no clock edge in between.
- R6: In the two-bit organisation, addr_i[2:1] selects the row and addr_i[0] selects the column pair p. Data bit k is stored in physical column 2p+k. Each of the eight words is read back as it was written.
- R7: In the two-bit organisation, address 3'b011 selects row 1 and column pair 1, which are cells 6 (bit 0) and 7 (bit 1). The other words are unchanged.
- R8: While rst_ni is low, every cell is cleared to 0, independently of the clock.
- R9: A read does not alter the cells. Repeated reads of the same address return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are stored on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all cells |
| addr_i | input | ADDR_W | Word address: row bits high, column bits low |
| data_i | input | DATA_W | Write data |
| we_i | input | 1 | 1 = write, 0 = read |
| cs_i | input | 1 | Chip-select; enables the column decoder |
| data_o | output | DATA_W | Read data; high-impedance unless a selected read |
| drive_o | output | 1 | Output buffer enable (1 during a selected read) |

## Verification
A fault in a decoder or in the cell write-enable shows up as another address changing state. It appears in the first read of that address after the faulty write, which is why every read is compared with a reference array indexed by the full address. A fault in the chip-select gating appears at once, as drive_o or as an ignored write that is stored anyway. A fault in the OR merge or in the bit-to-column mapping appears in the same cycle as the read. In the two-bit mode it appears as swapped or merged bits.

// File: rtl/coinc_ram_pkg.sv
package coinc_ram_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;
endpackage

// File: rtl/sel_decoder.sv
module sel_decoder #(
  parameter int unsigned IN_W = 2,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code_i,
  input  logic             en_i,
  output logic [OUT_N-1:0] sel_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign sel_o[i] = en_i && (code_i == IN_W'(i));
  end
endmodule

// File: rtl/cell_grid.sv
module cell_grid #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 4,
  parameter int unsigned DATA_W = 1,
  localparam int unsigned PAIRS = COLS / DATA_W,
  localparam int unsigned NCELL = ROWS * COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROWS-1:0]   row_sel_i,
  input  logic [PAIRS-1:0]  col_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCELL-1:0]  cells_o
);
  logic [NCELL-1:0] hit;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      logic sel;
      assign sel = row_sel_i[r] & col_sel_i[c / DATA_W];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cells_o[IDX] <= 1'b0;
        else if (sel && wr_i) cells_o[IDX] <= wdata_i[c % DATA_W];
      end
      assign hit[IDX] = sel & cells_o[IDX];
    end
  end

  // wired-OR of every selected cell onto its data bit line
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NCELL); i++) begin
      rdata_o[(i % COLS) % DATA_W] = rdata_o[(i % COLS) % DATA_W] | hit[i];
    end
  end
endmodule

// File: rtl/coinc_ram.sv
module coinc_ram
  import coinc_ram_pkg::*;
#(
  parameter int unsigned ROW_AW = 2,
  parameter int unsigned COL_AW = 2,
  parameter int unsigned DATA_W = 1,
  localparam int unsigned ROWS    = 1 << ROW_AW,
  localparam int unsigned COLS    = 1 << COL_AW,
  localparam int unsigned PAIR_AW = COL_AW - $clog2(DATA_W),
  localparam int unsigned PAIRS   = 1 << PAIR_AW,
  localparam int unsigned ADDR_W  = ROW_AW + PAIR_AW,
  localparam int unsigned NCELL   = ROWS * COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              we_i,
  input  logic              cs_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [ROWS-1:0]   row_sel;
  logic [PAIRS-1:0]  pair_sel;
  logic [DATA_W-1:0] rdata;
  logic [NCELL-1:0]  cells;
  acc_e              acc;

  assign acc = acc_e'(we_i);

  sel_decoder #(.IN_W(ROW_AW)) u_row_dec (
    .code_i (addr_i[ADDR_W-1 -: ROW_AW]),
    .en_i   (1'b1),
    .sel_o  (row_sel)
  );

  // chip-select gates only the column side
  sel_decoder #(.IN_W(PAIR_AW)) u_col_dec (
    .code_i (addr_i[PAIR_AW-1:0]),
    .en_i   (cs_i),
    .sel_o  (pair_sel)
  );

  cell_grid #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_grid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_sel_i (row_sel),
    .col_sel_i (pair_sel),
    .wr_i      (acc == ACC_WRITE),
    .wdata_i   (data_i),
    .rdata_o   (rdata),
    .cells_o   (cells)
  );

  assign drive_o = cs_i && (acc == ACC_READ);
  assign data_o  = drive_o ? rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/coinc_ram_chk.sv
module coinc_ram_chk #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned PAIRS  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 1,
  parameter int unsigned NCELL  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              drive_o,
  input logic [ROWS-1:0]   row_sel,
  input logic [PAIRS-1:0]  pair_sel,
  input logic [DATA_W-1:0] rdata,
  input logic [NCELL-1:0]  cells
);
  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(row_sel)); // R1
  AST_COL_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pair_sel)); // R1
  AST_ONE_WORD_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(cells ^ $past(cells)) <= DATA_W); // R1
  AST_NO_COL_WITHOUT_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> pair_sel == '0); // R3
  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !drive_o); // R3
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i) |=> $stable(cells)); // R4
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i) |-> !drive_o); // R4
  AST_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && $past(cs_i && !we_i) && $stable(addr_i)) |-> $stable(rdata)); // R9
endmodule

bind coinc_ram coinc_ram_chk #(
  .ROWS(ROWS), .PAIRS(PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCELL(NCELL)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .drive_o  (drive_o),
  .row_sel  (row_sel),
  .pair_sel (pair_sel),
  .rdata    (rdata),
  .cells    (cells)
);

// File: tb/test_coinc_ram.sv
module test_coinc_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // one-bit organisation
  logic [3:0] a1;
  logic [0:0] d1, q1;
  logic we1, cs1, drv1;
  // two-bit organisation
  logic [2:0] a2;
  logic [1:0] d2, q2;
  logic we2, cs2, drv2;

  coinc_ram #(.DATA_W(1)) i_coinc_ram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a1), .data_i(d1),
    .we_i(we1), .cs_i(cs1), .data_o(q1), .drive_o(drv1)
  );
  coinc_ram #(.DATA_W(2)) i_coinc_ram_w2 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a2), .data_i(d2),
    .we_i(we2), .cs_i(cs2), .data_o(q2), .drive_o(drv2)
  );

  int n_chk = 0;
  int n_err = 0;
  logic       ref1 [16];
  logic [1:0] ref2 [8];

  // {cs, we, addr[3:0], din, exp_drive, exp_q}
  localparam logic [8:0] VEC [18] = '{
    9'b1_1_1001_1_0_0,  // R2 write cell 9
    9'b1_0_1001_0_1_1,  // R2 read 9
    9'b1_0_1000_0_1_0,  // R2 cell 8 untouched
    9'b1_0_1101_0_1_0,  // R2 same column
    9'b1_0_1010_0_1_0,  // R2 same row
    9'b1_1_0000_1_0_0,
    9'b1_1_1111_1_0_0,
    9'b1_0_0000_0_1_1,
    9'b1_0_1111_0_1_1,
    9'b0_1_0011_1_0_0,  // R3 unselected write
    9'b1_0_0011_0_1_0,  // R3 nothing stored
    9'b0_0_1001_0_0_0,  // R3 unselected read
    9'b1_1_1001_0_0_0,
    9'b1_0_1001_0_1_0,
    9'b1_0_1111_0_1_1,
    9'b1_1_0110_1_0_0,
    9'b1_0_0110_0_1_1,
    9'b1_0_0111_0_1_0
  };

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic op1(input logic cs, input logic we, input logic [3:0] a, input logic d);
    @(negedge clk);
    cs1 = cs; we1 = we; a1 = a; d1 = d;
    if (cs && we) ref1[a] = d;
    #1;
  endtask

  task automatic op2(input logic cs, input logic we, input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    cs2 = cs; we2 = we; a2 = a; d2 = d;
    if (cs && we) ref2[a] = d;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cs1 = 0; we1 = 0; a1 = '0; d1 = '0;
    cs2 = 0; we2 = 0; a2 = '0; d2 = '0;
    for (int i = 0; i < 16; i++) ref1[i] = 1'b0;
    for (int i = 0; i < 8; i++) ref2[i] = 2'b00;
    repeat (3) @(posedge clk);
    // R8 reset state, read combinationally while still in reset
    cs1 = 1; a1 = 4'd9; #1;
    chk("R8 reset read", {1'b0, q1}, 2'b00);
    @(negedge clk); rst_n = 1'b1;

    // R5 combinational read of every cell after reset
    for (int i = 0; i < 16; i++) begin
      op1(1, 0, 4'(i), 0);
      chk("R5 post-reset sweep", {drv1, q1}, {1'b1, ref1[i]});
    end

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 18; i++) begin
      logic [8:0] v;
      v = VEC[i];
      op1(v[8], v[7], v[6:3], v[2]);
      if (!v[8]) chk("R3 table drive", {1'b0, drv1}, {1'b0, v[1]});
      else if (v[7]) chk("R4 table drive", {1'b0, drv1}, {1'b0, v[1]});
      else chk("R5 table read", {drv1, q1}, {v[1], v[0]});
    end

    // R1 checkerboard-like pattern, full sweep against reference
    for (int i = 0; i < 16; i++) op1(1, 1, 4'(i), 1'((i ^ (i >> 2)) & 1));
    for (int i = 0; i < 16; i++) begin
      op1(1, 0, 4'(i), 0);
      chk("R1 pattern sweep", {drv1, q1}, {1'b1, ref1[i]});
    end
    // R1 single write flips exactly one cell
    op1(1, 1, 4'd5, ~ref1[5]);
    for (int i = 0; i < 16; i++) begin
      op1(1, 0, 4'(i), 0);
      chk("R1 single write", {1'b0, q1}, {1'b0, ref1[i]});
    end

    // R9 repeated read
    op1(1, 0, 4'd5, 0);
    op1(1, 0, 4'd5, 0);
    chk("R9 reread", {1'b0, q1}, {1'b0, ref1[5]});

    // R4 write visible only after the edge; output released during write
    op1(1, 1, 4'd12, ~ref1[12]);
    chk("R4 no drive during write", {1'b0, drv1}, 2'b00);
    op1(1, 0, 4'd12, 0);
    chk("R4 stored at edge", {1'b0, q1}, {1'b0, ref1[12]});

    // R6 two-bit organisation, every word
    for (int i = 0; i < 8; i++) op2(1, 1, 3'(i), 2'((i * 3 + 1) & 3));
    for (int i = 0; i < 8; i++) begin
      op2(1, 0, 3'(i), 0);
      chk("R6 word sweep", q2, ref2[i]);
      chk("R6 drive", {1'b0, drv2}, 2'b01);
    end
    // R7 address 011 writes cells 6 and 7 only
    op2(1, 1, 3'b011, 2'b10);
    op2(1, 0, 3'b011, 0);
    chk("R7 addr 011", q2, 2'b10);
    op2(1, 0, 3'b010, 0);
    chk("R7 neighbour pair", q2, ref2[2]);
    op2(1, 0, 3'b111, 0);
    chk("R7 same column pair", q2, ref2[7]);
    // R3 in two-bit mode
    op2(0, 1, 3'b000, 2'b11);
    chk("R3 w2 no drive", {1'b0, drv2}, 2'b00);
    op2(1, 0, 3'b000, 0);
    chk("R3 w2 nothing stored", q2, ref2[0]);

    // R8 asynchronous reset mid-cycle
    @(negedge clk); #1; rst_n = 1'b0; #1;
    for (int i = 0; i < 16; i++) ref1[i] = 1'b0;
    for (int i = 0; i < 8; i++) ref2[i] = 2'b00;
    cs1 = 1; we1 = 0; a1 = 4'd5; cs2 = 1; we2 = 0; a2 = 3'b011; #1;
    chk("R8 async clear w1", {1'b0, q1}, 2'b00);
    chk("R8 async clear w2", q2, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      op1(1, 0, 4'(i), 0);
      chk("R8 cleared sweep", {1'b0, q1}, 2'b00);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule